// File: doc/BRIEF.md
# Serial Channel-Select Switch Controller

This block is the digital controller for a bank of analog switches. A host talks to it over a three-wire serial link made of a serial clock, an active-high select line and a data line. While select is high, each rising serial-clock edge shifts one bit into a four-bit command register. The command holds an enable flag and a three-bit channel number. When select drops, the controller turns every switch off at once. It waits a programmable number of system-clock cycles, then turns on the one switch named by the command, or keeps all switches off if the enable flag was clear.

The controller has two data pins, each with its own output enable, so that several controllers and a serial converter can share one host port. While select is high, bits pass from the first pin to the second, delayed by four serial clocks, so identical controllers can be daisy-chained. While select is low, the first pin carries back whatever arrives on the second pin, for example a converter's result stream.

All serial inputs are sampled with the system clock through synchronizers. Every delay is counted in system-clock cycles.

Top module: `chanmux_top`

## Requirements
- R1: The outputs `chanEn` hold at most one high bit at any time. Channel number k drives bit k.
- R2: While select is high, each rising serial-clock edge shifts the data-pin-1 level into the command register. While select is low, serial-clock edges leave the register unchanged.
- R3: Command bits arrive most significant first: the enable flag (bit 3), then channel bits B2, B1, B0. The channel number is B2..B0 read as an unsigned value.
- R4: If more than four bits are shifted in one select-high window, only the last four bits form the command.
- R5: When select falls, `chanEn` is cleared three system cycles after the falling level is driven. This delay covers two synchronizer stages and one register. The selected bit rises exactly `ON_DELAY` cycles after that clear, so channels are always switched break-before-make.
- R6: A command whose enable flag is 0 keeps all channels off after select falls.
- R7: After select rises again, the active channel stays on and is cleared `OFF_DELAY + 3` system cycles after the rising level is driven.
- R8: While select is high, data pin 2 is driven (`data2Oe` = 1). It carries the bit shifted out of the oldest register stage, which is the data-pin-1 bit from four shifts earlier.
- R9: While select is low, data pin 1 is driven (`data1Oe` = 1) with the level present on data pin 2. The two output enables are never high together.
- R10: During and right after reset, `chanEn` is 0 and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock |
| selectN | input | 1 | Select line; high = load command, low = apply command |
| data1In | input | 1 | Data pin 1, input side |
| data1Out | output | 1 | Data pin 1, output side |
| data1Oe | output | 1 | Drive enable for data pin 1 |
| data2In | input | 1 | Data pin 2, input side |
| data2Out | output | 1 | Data pin 2, output side |
| data2Oe | output | 1 | Drive enable for data pin 2 |
| chanEn | output | NUM_CH | One-hot switch enables |

## Verification
The embedded properties check on every cycle that:
- at most one switch is enabled;
- an active switch can only change to all-off;
- a select falling edge always clears the switches;
- the shift register holds while select is low;
- the two pin drivers never overlap.

Only the bench scenarios can show the exact on and off latencies, the decoding of channel numbers, the last-four-bits rule, the four-clock forwarding delay and the return path through data pin 1. A scoreboard compares each of these against the command that produced it.

// File: rtl/chanmux_pkg.sv
package chanmux_pkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic clearAll;   // switch every channel off
    logic latchCmd;   // copy shift register into command register
    logic applyCmd;   // drive the decoded command onto the switches
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_LIVE  = 2'd2,
    ST_DRAIN = 2'd3
  } seqState_t;

endpackage

// File: rtl/chanmux_sync.sv
module chanmux_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic syncOut,
  output logic prevOut
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign syncOut = chain[STAGES-1];
  assign prevOut = chain[STAGES];
endmodule

// File: rtl/chanmux_datapath.sv
module chanmux_datapath
  import chanmux_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_BITS    = $clog2(NUM_CH),
  localparam int CMD_BITS   = CH_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              selectN,
  input  logic              data1In,
  input  logic              data2In,
  input  ctrlStrobes_t      strobes,
  output logic              selFall,
  output logic              selRise,
  output logic              data1Out,
  output logic              data1Oe,
  output logic              data2Out,
  output logic              data2Oe,
  output logic [NUM_CH-1:0] chanEn
);
  logic clkSync, clkPrev, selSync, selPrev, datSync, datPrev;

  chanmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncClk (
    .clk(clk), .rst_n(rst_n), .din(serClk), .syncOut(clkSync), .prevOut(clkPrev));
  chanmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSel (
    .clk(clk), .rst_n(rst_n), .din(selectN), .syncOut(selSync), .prevOut(selPrev));
  chanmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncDat (
    .clk(clk), .rst_n(rst_n), .din(data1In), .syncOut(datSync), .prevOut(datPrev));

  logic serRise;
  assign serRise = clkSync & ~clkPrev;
  assign selFall = selPrev & ~selSync;
  assign selRise = selSync & ~selPrev;

  // Command shift register, newest bit at LSB
  logic [CMD_BITS-1:0] shiftReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   shiftReg <= '0;
    else if (serRise && selSync)  shiftReg <= {shiftReg[CMD_BITS-2:0], datSync};
  end

  logic [CMD_BITS-1:0] cmdReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cmdReg <= '0;
    else if (strobes.latchCmd) cmdReg <= shiftReg;
  end

  // Channel decoder
  logic [NUM_CH-1:0] decoded;
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign decoded[i] = cmdReg[CMD_BITS-1] && (cmdReg[CH_BITS-1:0] == CH_BITS'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chanEn <= '0;
    else if (strobes.clearAll) chanEn <= '0;
    else if (strobes.applyCmd) chanEn <= decoded;
  end

  // Pin direction, both released in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data1Oe <= 1'b0;
      data2Oe <= 1'b0;
    end else begin
      data2Oe <= selSync;
      data1Oe <= ~selSync;
    end
  end

  assign data2Out = shiftReg[CMD_BITS-1];
  assign data1Out = data2In;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chanEn));

  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !selSync |=> $stable(shiftReg));

  assert_pins_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(data1Oe && data2Oe));
endmodule

// File: rtl/chanmux_control.sv
module chanmux_control
  import chanmux_pkg::*;
#(
  parameter int ON_DELAY  = 4,
  parameter int OFF_DELAY = 3,
  localparam int MAX_DLY  = (ON_DELAY > OFF_DELAY) ? ON_DELAY : OFF_DELAY,
  localparam int CNT_W    = $clog2(MAX_DLY + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         selFall,
  input  logic         selRise,
  output ctrlStrobes_t strobes
);
  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic restart;

  always_comb begin
    nextState = state;
    strobes   = '0;
    restart   = 1'b0;
    if (selFall) begin
      strobes.clearAll = 1'b1;
      strobes.latchCmd = 1'b1;
      nextState        = ST_ARM;
      restart          = 1'b1;
    end else begin
      unique case (state)
        ST_ARM: begin
          if (selRise) nextState = ST_IDLE;
          else if (cnt == CNT_W'(ON_DELAY - 1)) begin
            strobes.applyCmd = 1'b1;
            nextState        = ST_LIVE;
          end
        end
        ST_LIVE: begin
          if (selRise) begin
            nextState = ST_DRAIN;
            restart   = 1'b1;
          end
        end
        ST_DRAIN: begin
          if (cnt == CNT_W'(OFF_DELAY - 1)) begin
            strobes.clearAll = 1'b1;
            nextState        = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (restart)                                   cnt <= '0;
      else if (state == ST_ARM || state == ST_DRAIN) cnt <= cnt + 1'b1;
    end
  end

  assert_counter_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_DLY));
endmodule

// File: rtl/chanmux_top.sv
module chanmux_top
  import chanmux_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ON_DELAY    = 4,
  parameter int OFF_DELAY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              selectN,
  input  logic              data1In,
  output logic              data1Out,
  output logic              data1Oe,
  input  logic              data2In,
  output logic              data2Out,
  output logic              data2Oe,
  output logic [NUM_CH-1:0] chanEn
);
  ctrlStrobes_t strobes;
  logic selFall, selRise;

  chanmux_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .selectN(selectN),
    .data1In(data1In), .data2In(data2In), .strobes(strobes),
    .selFall(selFall), .selRise(selRise),
    .data1Out(data1Out), .data1Oe(data1Oe),
    .data2Out(data2Out), .data2Oe(data2Oe), .chanEn(chanEn));

  chanmux_control #(.ON_DELAY(ON_DELAY), .OFF_DELAY(OFF_DELAY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .selFall(selFall), .selRise(selRise),
    .strobes(strobes));

  assert_break_before_make_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(chanEn)) && (chanEn != $past(chanEn))) |-> (chanEn == '0));

  assert_fall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    selFall |=> (chanEn == '0));
endmodule

// File: tb/test_chanmux_top.sv
module test_chanmux_top;
  localparam int NUM_CH = 8;
  localparam int ON_DLY = 4;
  localparam int OFF_DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0;
  logic selPin = 1'b0;
  logic data1In = 1'b0;
  logic data2In = 1'b0;
  logic data1Out, data1Oe, data2Out, data2Oe;
  logic [NUM_CH-1:0] chanEn;

  int nTests = 0;
  int nFail = 0;

  typedef struct { bit en; int ch; } expItem_t;
  expItem_t expQ[$];
  logic [3:0] model = 4'b0000;   // bench view of the last four bits shifted

  always #2.5 clk = ~clk;

  chanmux_top #(.NUM_CH(NUM_CH), .ON_DELAY(ON_DLY), .OFF_DELAY(OFF_DLY)) i_chanmux_top (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .selectN(selPin),
    .data1In(data1In), .data1Out(data1Out), .data1Oe(data1Oe),
    .data2In(data2In), .data2Out(data2Out), .data2Oe(data2Oe), .chanEn(chanEn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Shift one bit while select is high (R2, R8)
  task automatic shiftBit(input bit b);
    data1In = b;
    tick(4);
    serClk = 1'b1;
    tick(4);
    serClk = 1'b0;
    tick(4);
    model = {model[2:0], b};
    check(data2Out == model[3], "R8 forwarded bit", data2Out, model[3]);
    check(data2Oe == 1'b1 && data1Oe == 1'b0, "R8 pin2 driven", data2Oe, 1);
  endtask

  // Raise select with a channel on and time its turn-off (R7)
  task automatic raiseSel();
    int n = 0;
    selPin = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (chanEn != '0 && n < 40);
    check(n == OFF_DLY + 3, "R7 off latency", n, OFF_DLY + 3);
  endtask

  task automatic dropSel(input bit en, input int ch);
    expItem_t it;
    it.en = en;
    it.ch = ch;
    expQ.push_back(it);
    selPin = 1'b0;
    tick(ON_DLY + 12);
  endtask

  task automatic sendCmd(input bit en, input int ch);
    if (chanEn != '0) raiseSel(); else selPin = 1'b1;
    tick(4);
    shiftBit(en);
    for (int k = 2; k >= 0; k--) shiftBit(ch[k]);
    dropSel(en, ch);
  endtask

  // Scoreboard monitor: checks each applied command (R1, R3, R5, R6)
  initial begin
    forever begin
      @(negedge selPin);
      if (expQ.size() > 0) begin
        expItem_t it;
        int n;
        it = expQ.pop_front();
        n = 0;
        if (it.en) begin
          do begin
            @(negedge clk);
            n++;
            if (n == 3) check(chanEn == '0, "R5 cleared on fall", chanEn, 0);
          end while (chanEn == '0 && n < 40);
          check(n == ON_DLY + 3, "R5 on latency", n, ON_DLY + 3);
          check(chanEn == NUM_CH'(1) << it.ch, "R1 R3 onehot channel", chanEn, 1 << it.ch);
        end else begin
          bit allOff = 1'b1;
          for (int i = 0; i < ON_DLY + 8; i++) begin
            @(negedge clk);
            if (chanEn != '0) allOff = 1'b0;
          end
          check(allOff, "R6 disabled stays off", chanEn, 0);
        end
      end
    end
  end

  initial begin
    #(5 * 150000);
    nFail++;
    nTests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tick(2);
    check(chanEn == '0, "R10 reset chanEn", chanEn, 0);
    check(data1Oe == 1'b0 && data2Oe == 1'b0, "R10 reset pins released", {data1Oe, data2Oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(chanEn == '0, "R10 after reset chanEn", chanEn, 0);
    tick(4);

    sendCmd(1'b1, 5);
    sendCmd(1'b1, 0);
    sendCmd(1'b1, 7);
    sendCmd(1'b0, 3);
    sendCmd(1'b1, 2);

    // R4: six bits, the last four (1,1,1,0) name channel 6
    raiseSel();
    tick(4);
    shiftBit(1'b0);
    shiftBit(1'b1);
    shiftBit(1'b1);
    shiftBit(1'b1);
    shiftBit(1'b1);
    shiftBit(1'b0);
    dropSel(1'b1, 6);
    check(chanEn == 8'h40, "R4 last four bits", chanEn, 8'h40);

    // R9: return path while select is low
    data2In = 1'b1;
    tick(1);
    check(data1Out == 1'b1 && data1Oe == 1'b1 && data2Oe == 1'b0, "R9 pin1 carries pin2 high", data1Out, 1);
    data2In = 1'b0;
    tick(1);
    check(data1Out == 1'b0 && data1Oe == 1'b1, "R9 pin1 carries pin2 low", data1Out, 0);

    // R2: serial clocks while select is low do not alter the command
    for (int i = 0; i < 4; i++) begin
      data1In = 1'b0;
      tick(4);
      serClk = 1'b1;
      tick(4);
      serClk = 1'b0;
    end
    tick(4);
    check(chanEn == 8'h40, "R2 no shift when low, channel kept", chanEn, 8'h40);
    raiseSel();
    tick(6);
    check(data2Out == model[3], "R2 register unchanged", data2Out, model[3]);
    dropSel(1'b1, 6);
    check(chanEn == 8'h40, "R2 same command reapplied", chanEn, 8'h40);

    tick(10);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule